// File: doc/BRIEF.md
# Carry-Lookahead Adder-Subtractor

This block adds or subtracts two 8-bit two's-complement operands in a single combinational path. One control input picks the operation. When it is high, every bit of the second operand is flipped by an XOR, and the same input is used as the carry into bit 0. Together these form the two's complement of the second operand, so one adder datapath serves both operations.

The datapath is split into 4-bit groups. Each bit cell produces a sum, a carry, a generate term and a propagate term. Each group's carry-out comes from lookahead logic over those terms, written as two levels of NAND. That carry feeds the next group. The final carry is exported, together with a signed overflow flag formed from the carries into and out of the most significant bit. There is no clock and no state.

Top module: `addsub_cla`

## Requirements
- R1: With `sub_mode` = 0, `result` equals (`op_a` + `op_b`) modulo 256.
- R2: With `sub_mode` = 1, `result` equals (`op_a` - `op_b`) modulo 256.
- R3: With `sub_mode` = 0, `carry_out` is 1 exactly when the unsigned sum of the operands exceeds 255.
- R4: With `sub_mode` = 1, `carry_out` is 1 exactly when `op_a` >= `op_b` as unsigned values, meaning no borrow. Subtracting zero therefore gives `carry_out` = 1.
- R5: In both modes, `overflow` is 1 exactly when the signed (two's-complement) result lies outside -128..127.
- R6: All outputs are purely combinational. They follow the inputs within the same clock period as an input change, with no registered delay.
- R7: Each 4-bit group's lookahead carry-out equals the carry that would ripple through its four cells. A carry entering at bit 0 propagates through every bit, for example 0xFF + 0x01 gives `result` 0x00 and `carry_out` 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a | input | 8 | First operand (minuend when subtracting) |
| op_b | input | 8 | Second operand (subtrahend when subtracting) |
| sub_mode | input | 1 | 0 = add, 1 = subtract; also the carry into bit 0 |
| result | output | 8 | Sum or difference, modulo 256 |
| carry_out | output | 1 | Carry out of the top group |
| overflow | output | 1 | Signed two's-complement overflow |

## Verification
Every result of this block is due zero cycles after its stimulus, because no register lies anywhere on the path from operand to output. The driver applies one operand pair and mode on each rising clock edge and queues the expected sum, carry and overflow. The monitor pops that entry on the following falling edge, which is half a period later and still within the same cycle. This keeps each comparison tied to the inputs that produced it. The run covers all 2^17 input combinations, plus directed entries for full carry propagation, overflow at both signed limits and subtracting zero.

// File: rtl/addsub_pkg.sv
package addsub_pkg;
   localparam int unsigned DEF_WIDTH = 8;
   localparam int unsigned DEF_GROUP = 4;

   typedef enum logic {
      MODE_ADD = 1'b0,
      MODE_SUB = 1'b1
   } op_mode_e;
endpackage

// File: rtl/cla_bit_cell.sv
// One bit slice: conditional operand inversion, then generate/propagate/sum/carry.
module cla_bit_cell (
   input  logic a_bit,
   input  logic b_bit,
   input  logic invert,
   input  logic c_in,
   output logic s_out,
   output logic c_out,
   output logic gen,
   output logic prop
);
   logic b_eff;

   assign b_eff = b_bit ^ invert;
   assign gen   = a_bit & b_eff;
   assign prop  = a_bit ^ b_eff;
   assign s_out = prop ^ c_in;
   assign c_out = gen | (prop & c_in);
endmodule

// File: rtl/cla_group.sv
// A group of N bit cells. The group carry-out is either lookahead (NAND-NAND)
// or taken from the internal ripple, chosen by USE_LOOKAHEAD.
module cla_group #(
   parameter int unsigned N             = 4,
   parameter bit          USE_LOOKAHEAD = 1'b1
) (
   input  logic [N-1:0] a_slice,
   input  logic [N-1:0] b_slice,
   input  logic         invert,
   input  logic         grp_cin,
   output logic [N-1:0] sum_slice,
   output logic         grp_cout,
   output logic         msb_cin
);
   if (N < 1) begin : g_bad_n
      $error("cla_group: N must be at least 1");
   end

   logic [N:0]   ripple_c;
   logic [N-1:0] g_vec;
   logic [N-1:0] p_vec;

   assign ripple_c[0] = grp_cin;

   for (genvar k = 0; k < N; k++) begin : g_cell
      cla_bit_cell u_cell (
         .a_bit (a_slice[k]),
         .b_bit (b_slice[k]),
         .invert(invert),
         .c_in  (ripple_c[k]),
         .s_out (sum_slice[k]),
         .c_out (ripple_c[k+1]),
         .gen   (g_vec[k]),
         .prop  (p_vec[k])
      );
   end

   assign msb_cin = ripple_c[N-1];

   if (USE_LOOKAHEAD) begin : g_lookahead
      // First NAND level: one term per generate position plus one for the carry-in.
      logic [N:0] nand_term;

      always_comb begin
         logic prod;
         for (int k = 0; k < N; k++) begin
            prod = g_vec[k];
            for (int j = k + 1; j < N; j++) begin
               prod = prod & p_vec[j];
            end
            nand_term[k] = ~prod;
         end
         nand_term[N] = ~((&p_vec) & grp_cin);
      end

      // Second NAND level gathers the terms into the group carry.
      assign grp_cout = ~(&nand_term);

      // Lookahead carry must agree with the ripple through the same cells.
      always_comb begin
         p_lookahead_match_r7: assert (grp_cout == ripple_c[N])
            else $error("lookahead carry disagrees with ripple carry");
      end
   end else begin : g_ripple
      assign grp_cout = ripple_c[N];
   end
endmodule

// File: rtl/addsub_cla.sv
// Two's-complement adder/subtractor made of cascaded lookahead groups.
module addsub_cla
   import addsub_pkg::*;
#(
   parameter int unsigned WIDTH         = DEF_WIDTH,
   parameter int unsigned GROUP         = DEF_GROUP,
   parameter bit          USE_LOOKAHEAD = 1'b1
) (
   input  logic [WIDTH-1:0] op_a,
   input  logic [WIDTH-1:0] op_b,
   input  logic             sub_mode,
   output logic [WIDTH-1:0] result,
   output logic             carry_out,
   output logic             overflow
);
   localparam int unsigned NGRP = WIDTH / GROUP;

   if (GROUP < 2) begin : g_bad_group
      $error("addsub_cla: GROUP must be at least 2");
   end
   if (WIDTH < GROUP || (WIDTH % GROUP) != 0) begin : g_bad_width
      $error("addsub_cla: WIDTH must be a whole multiple of GROUP");
   end

   op_mode_e         mode;
   logic             sub_en;
   logic [NGRP:0]    chain_c;
   logic [NGRP-1:0]  grp_msbc;

   assign mode       = op_mode_e'(sub_mode);
   assign sub_en     = (mode == MODE_SUB);
   assign chain_c[0] = sub_en;

   for (genvar gi = 0; gi < NGRP; gi++) begin : g_grp
      cla_group #(
         .N            (GROUP),
         .USE_LOOKAHEAD(USE_LOOKAHEAD)
      ) u_grp (
         .a_slice  (op_a[gi*GROUP +: GROUP]),
         .b_slice  (op_b[gi*GROUP +: GROUP]),
         .invert   (sub_en),
         .grp_cin  (chain_c[gi]),
         .sum_slice(result[gi*GROUP +: GROUP]),
         .grp_cout (chain_c[gi+1]),
         .msb_cin  (grp_msbc[gi])
      );
   end

   assign carry_out = chain_c[NGRP];
   assign overflow  = grp_msbc[NGRP-1] ^ chain_c[NGRP];

   // ---------------- assertions ----------------
   logic [WIDTH-1:0] b_eff_chk;
   assign b_eff_chk = op_b ^ {WIDTH{sub_mode}};

   always_comb begin
      if (!sub_mode) begin
         p_add_r1: assert ({carry_out, result} == ({1'b0, op_a} + {1'b0, op_b}))
            else $error("addition result or carry wrong");
      end else begin
         p_sub_r2: assert (result == WIDTH'(op_a - op_b))
            else $error("subtraction result wrong");
         p_noborrow_r4: assert (carry_out == (op_a >= op_b))
            else $error("subtraction carry wrong");
      end
      p_no_overflow_r5: assert (overflow ==
            ((op_a[WIDTH-1] == b_eff_chk[WIDTH-1]) && (result[WIDTH-1] != op_a[WIDTH-1])))
         else $error("signed overflow flag wrong");
   end

   for (genvar gi = 0; gi < NGRP; gi++) begin : g_chk
      localparam int unsigned TOP = gi * GROUP + GROUP - 1;
      always_comb begin
         p_grp_carry_r7: assert (chain_c[gi+1] ==
               ((op_a[TOP] & b_eff_chk[TOP]) | ((op_a[TOP] ^ b_eff_chk[TOP]) & grp_msbc[gi])))
            else $error("group carry-out inconsistent with its top cell");
      end
   end
endmodule

// File: tb/sim_addsub_cla.sv
`timescale 1ns/1ps
module sim_addsub_cla;
   localparam int W = 8;
   localparam int WATCHDOG = 190000;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] op_a = '0;
   logic [W-1:0] op_b = '0;
   logic         sub_mode = 1'b0;
   logic [W-1:0] result;
   logic         carry_out;
   logic         overflow;

   int checks = 0;
   int errors = 0;
   bit drive_done = 1'b0;

   typedef struct {
      logic [W-1:0] res;
      logic         cy;
      logic         ov;
      string        rtag;
      string        ctag;
   } exp_t;

   exp_t sb_q[$];

   always #10 clk = ~clk;

   addsub_cla u0 (
      .op_a     (op_a),
      .op_b     (op_b),
      .sub_mode (sub_mode),
      .result   (result),
      .carry_out(carry_out),
      .overflow (overflow)
   );

   function automatic exp_t model(input int a, input int b, input bit m);
      exp_t e;
      int sa, sb, sr;
      sa = (a > 127) ? a - 256 : a;
      sb = (b > 127) ? b - 256 : b;
      if (!m) begin
         e.res = W'((a + b) % 256);
         e.cy  = (a + b) > 255;
         sr    = sa + sb;
      end else begin
         e.res = W'((a - b + 256) % 256);
         e.cy  = (a >= b);
         sr    = sa - sb;
      end
      e.ov = (sr > 127) || (sr < -128);
      return e;
   endfunction

   task automatic drive(input int a, input int b, input bit m,
                        input string rtag, input string ctag);
      exp_t e;
      @(posedge clk);
      op_a     = W'(a);
      op_b     = W'(b);
      sub_mode = m;
      e      = model(a, b, m);
      e.rtag = rtag;
      e.ctag = ctag;
      sb_q.push_back(e);
   endtask

   // Monitor: results are combinational, due in the same cycle; sample at falling edge.
   initial begin
      exp_t e;
      forever begin
         @(negedge clk);
         if (sb_q.size() > 0) begin
            e = sb_q.pop_front();
            checks++;
            if (result !== e.res) begin
               errors++;
               $display("FAIL %s result: actual=%h expected=%h (a=%h b=%h m=%0b)",
                        e.rtag, result, e.res, op_a, op_b, sub_mode);
            end
            checks++;
            if (carry_out !== e.cy) begin
               errors++;
               $display("FAIL %s carry_out: actual=%0b expected=%0b (a=%h b=%h m=%0b)",
                        e.ctag, carry_out, e.cy, op_a, op_b, sub_mode);
            end
            checks++;
            if (overflow !== e.ov) begin
               errors++;
               $display("FAIL R5 overflow: actual=%0b expected=%0b (a=%h b=%h m=%0b)",
                        overflow, e.ov, op_a, op_b, sub_mode);
            end
         end
      end
   end

   // Driver
   initial begin
      repeat (3) @(posedge clk);
      rst = 1'b0;
      // state right after reset: zero operands in add mode
      drive(8'h00, 8'h00, 1'b0, "R1", "R3");
      // R7: carry entering bit 0 travels through both groups
      drive(8'hFF, 8'h01, 1'b0, "R7", "R7");
      drive(8'h0F, 8'h01, 1'b0, "R7", "R3");
      // R5: overflow at both signed limits
      drive(8'h7F, 8'h01, 1'b0, "R1", "R3");
      drive(8'h80, 8'h01, 1'b1, "R2", "R4");
      drive(8'h80, 8'h80, 1'b0, "R1", "R3");
      // R4: subtracting zero gives no borrow; R2 wrap below zero
      drive(8'h00, 8'h00, 1'b1, "R2", "R4");
      drive(8'h00, 8'h01, 1'b1, "R2", "R4");
      // R6: an input change is visible in the same cycle
      drive(8'h55, 8'hAA, 1'b0, "R6", "R6");
      drive(8'h55, 8'hAA, 1'b1, "R6", "R6");
      // exhaustive sweep of all operand and mode combinations
      for (int m = 0; m < 2; m++) begin
         for (int x = 0; x < 256; x++) begin
            for (int y = 0; y < 256; y++) begin
               drive(x, y, m[0], m[0] ? "R2" : "R1", m[0] ? "R4" : "R3");
            end
         end
      end
      @(posedge clk);
      @(posedge clk);
      drive_done = 1'b1;
   end

   // Completion and watchdog
   initial begin
      int cyc;
      cyc = 0;
      while (!(drive_done && sb_q.size() == 0) && cyc < WATCHDOG) begin
         @(posedge clk);
         cyc++;
      end
      if (cyc >= WATCHDOG) begin
         checks++;
         errors++;
         $display("FAIL R6 watchdog: actual=%0d cycles expected=completion", cyc);
      end
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule